// File: doc/BRIEF.md
# Vectored Interrupt Controller with Priority Chain

The block gathers eight interrupt conditions that come from neighbouring logic (serial channels, a timer, input-change detectors). It samples their levels into a status register, gates them with a mask register, and raises an active-low interrupt request whenever an unmasked condition is present. A host reaches the block through a small register port with a select, a read strobe and a write strobe. Through this port it reads the status, writes the mask and programs an interrupt vector.

When the host acknowledges an interrupt, the block drives the programmed vector onto the data bus. At other times it leaves the bus undriven. An optional chain mode lets several controllers share one acknowledge by priority. A device answers only when its enable input is high, and it holds its enable output low while it has a pending or in-service interrupt. With chain mode off, the two chain pins act as a plain input and a plain output.

Top module: `irqvec_chain`

## Requirements
- R1: The status register (address 0) shows the source levels as sampled at the previous clock edge. Writes to address 0 have no effect.
- R2: `irq_n` is 0 exactly when some status bit and the matching mask bit are both 1. Otherwise it is 1.
- R3: After reset: the mask (address 1) reads 0x00, the vector (address 2) reads 0x0F, the control register (address 3) reads 0x00, `irq_n` is 1 and `bus_oe` is 0.
- R4: The mask and the vector read back the last value written to them.
- R5: An acknowledge (`iack_n` low) while an unmasked condition is pending and the device is enabled drives `bus_oe`=1 and `bus_rdata`=vector. An acknowledge with nothing pending leaves `bus_oe`=0.
- R6: In chain mode (control bit 0 = 1), an acknowledge is answered only when `ie_in` is 1.
- R7: In chain mode, `ie_out` = `ie_in` AND NOT (pending OR in-service).
- R8: An answered acknowledge sets the in-service flag (control bit 3). Writing control with bit 2 = 1 clears it.
- R9: With chain mode off, `ie_out` follows control bit 1, and control bit 4 reads the level of `ie_in`.
- R10: While `iack_n` is low, register reads are ignored. The bus carries the vector if the acknowledge is answered, and is undriven otherwise.
- R11: A register write that takes effect in the same cycle as an answered acknowledge changes neither the vector driven in that cycle nor the setting of the in-service flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_level | input | 8 | Interrupt condition levels |
| bus_cs | input | 1 | Register select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read or vector data |
| bus_oe | output | 1 | Data bus drive enable |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| irq_n | output | 1 | Active-low interrupt request |
| ie_in | input | 1 | Chain enable in / general input |
| ie_out | output | 1 | Chain enable out / general output |

## Verification
An acknowledge and a host write to the mask can land in the same cycle. The bench provokes this by pulling `iack_n` low and, in the same cycle, writing a mask that removes the only pending condition. It expects the old vector on the bus before the edge. After the edge it expects the request released, the bus undriven, and the in-service flag set. Acknowledge together with a register read is also provoked, and the vector must win.

// File: rtl/irqvec_chain.sv
module irqvec_chain #(
  parameter int NSRC = 8,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_level,
  input  logic            bus_cs,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            bus_oe,
  input  logic            iack_n,
  output logic            irq_n,
  input  logic            ie_in,
  output logic            ie_out
);
  logic [NSRC-1:0] status_q, mask_q;
  logic [7:0]      vec_q;
  logic            chain_q, gpo_q, insvc_q;
  logic            pending, ack_take, wr_en, rd_en;
  logic [7:0]      rd_mux;

  assign pending  = |(status_q & mask_q);
  assign ack_take = !iack_n && pending && (!chain_q || ie_in);
  assign wr_en    = bus_cs && bus_wr;
  assign rd_en    = bus_cs && bus_rd && iack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      vec_q    <= VEC_RST;
      chain_q  <= 1'b0;
      gpo_q    <= 1'b0;
      insvc_q  <= 1'b0;
    end else begin
      status_q <= src_level;
      if (wr_en) begin
        case (bus_addr)
          2'd1: mask_q <= bus_wdata[NSRC-1:0];
          2'd2: vec_q  <= bus_wdata;
          2'd3: begin
            chain_q <= bus_wdata[0];
            gpo_q   <= bus_wdata[1];
          end
          default: ;
        endcase
      end
      if (ack_take)
        insvc_q <= 1'b1;
      else if (wr_en && bus_addr == 2'd3 && bus_wdata[2])
        insvc_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      2'd0: rd_mux[NSRC-1:0] = status_q;
      2'd1: rd_mux[NSRC-1:0] = mask_q;
      2'd2: rd_mux = vec_q;
      default: rd_mux = {3'b000, ie_in, insvc_q, 1'b0, gpo_q, chain_q};
    endcase
  end

  assign bus_oe    = ack_take || rd_en;
  assign bus_rdata = ack_take ? vec_q : (rd_en ? rd_mux : 8'h00);
  assign irq_n     = !pending;
  assign ie_out    = chain_q ? (ie_in && !pending && !insvc_q) : gpo_q;
endmodule

// File: rtl/irqvec_chain_chk.sv
module irqvec_chain_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_level,
  input logic [NSRC-1:0] status_q,
  input logic [NSRC-1:0] mask_q,
  input logic [7:0]      vec_q,
  input logic            chain_q,
  input logic            insvc_q,
  input logic            iack_n,
  input logic            ie_in,
  input logic            ie_out,
  input logic            irq_n,
  input logic            bus_oe,
  input logic [7:0]      bus_rdata
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  // R1
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> status_q == $past(src_level));

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n == 1'b0) |-> ((status_q & mask_q) != '0));

  // R5
  vector_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !iack_n) |-> bus_rdata == vec_q);

  // R6
  chain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && !ie_in && !iack_n) |-> !bus_oe);

  // R7
  chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && (!ie_in || !irq_n || insvc_q)) |-> !ie_out);

  // R8
  insvc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !iack_n) |=> insvc_q);
endmodule

bind irqvec_chain irqvec_chain_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_level(src_level), .status_q(status_q),
  .mask_q(mask_q), .vec_q(vec_q), .chain_q(chain_q), .insvc_q(insvc_q),
  .iack_n(iack_n), .ie_in(ie_in), .ie_out(ie_out), .irq_n(irq_n),
  .bus_oe(bus_oe), .bus_rdata(bus_rdata)
);

// File: tb/irqvec_chain_tb_top.sv
`timescale 1ns/1ps
module irqvec_chain_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] src_level = 0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic bus_oe, irq_n, ie_out;
  logic iack_n = 1, ie_in = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqvec_chain dut_i (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .bus_cs(bus_cs),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .iack_n(iack_n), .irq_n(irq_n), .ie_in(ie_in), .ie_out(ie_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R3 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R3 bus_oe", {7'b0, bus_oe}, 8'h00);
    rd_reg(2'd1, v); chk("R3 mask", v, 8'h00);
    rd_reg(2'd2, v); chk("R3 vector", v, 8'h0F);
    rd_reg(2'd3, v); chk("R3 control", v, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    src_level = 8'hA5;
    settle();
    rd_reg(2'd0, v); chk("R1 status", v, 8'hA5);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd0, v); chk("R1 status write ignored", v, 8'hA5);
    chk("R2 masked no irq", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr_reg(2'd1, 8'h04);
    chk("R2 unmasked irq", {7'b0, irq_n}, 8'h00);
    rd_reg(2'd1, v); chk("R4 mask readback", v, 8'h04);
    wr_reg(2'd1, 8'h02);
    chk("R2 bit mismatch no irq", {7'b0, irq_n}, 8'h01);
    src_level = 8'h02;
    settle();
    chk("R2 source change irq", {7'b0, irq_n}, 8'h00);
  endtask

  task automatic t_vector;
    logic [7:0] v;
    wr_reg(2'd2, 8'h42);
    rd_reg(2'd2, v); chk("R4 vector readback", v, 8'h42);
    @(negedge clk); iack_n = 0; #1;
    chk("R5 ack oe", {7'b0, bus_oe}, 8'h01);
    chk("R5 ack vector", bus_rdata, 8'h42);
    @(negedge clk); iack_n = 1;
    wr_reg(2'd1, 8'h00);
    @(negedge clk); iack_n = 0; #1;
    chk("R5 ack no pending", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); iack_n = 1;
  endtask

  task automatic t_ack_read;
    @(negedge clk); iack_n = 0; bus_cs = 1; bus_rd = 1; bus_addr = 2'd1; #1;
    chk("R10 read ignored in ack", {7'b0, bus_oe}, 8'h00);
    bus_cs = 0; bus_rd = 0; iack_n = 1;
    wr_reg(2'd1, 8'h02);
    @(negedge clk); iack_n = 0; bus_cs = 1; bus_rd = 1; bus_addr = 2'd1; #1;
    chk("R10 ack wins over read", bus_rdata, 8'h42);
    bus_cs = 0; bus_rd = 0; iack_n = 1;
  endtask

  task automatic t_chain;
    logic [7:0] v;
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd3, 8'h05);
    rd_reg(2'd3, v); chk("R8 in-service cleared", v & 8'h08, 8'h00);
    ie_in = 1; #1;
    chk("R7 pass idle", {7'b0, ie_out}, 8'h01);
    ie_in = 0; #1;
    chk("R7 upstream low", {7'b0, ie_out}, 8'h00);
    wr_reg(2'd1, 8'h02);
    ie_in = 1; #1;
    chk("R7 pending blocks", {7'b0, ie_out}, 8'h00);
    ie_in = 0;
    @(negedge clk); iack_n = 0; #1;
    chk("R6 ack blocked", {7'b0, bus_oe}, 8'h00);
    @(negedge clk); iack_n = 1;
    rd_reg(2'd3, v); chk("R6 no in-service", v & 8'h08, 8'h00);
    ie_in = 1;
    @(negedge clk); iack_n = 0; #1;
    chk("R6 ack allowed", bus_rdata, 8'h42);
    @(negedge clk); iack_n = 1;
    wr_reg(2'd1, 8'h00);
    chk("R8 in-service holds chain", {7'b0, ie_out}, 8'h00);
    rd_reg(2'd3, v); chk("R8 in-service set", v & 8'h08, 8'h08);
    wr_reg(2'd3, 8'h05);
    chk("R8 clear releases chain", {7'b0, ie_out}, 8'h01);
  endtask

  task automatic t_gp;
    logic [7:0] v;
    wr_reg(2'd3, 8'h02);
    chk("R9 gp out high", {7'b0, ie_out}, 8'h01);
    ie_in = 0;
    rd_reg(2'd3, v); chk("R9 gp in low", v, 8'h02);
    ie_in = 1;
    rd_reg(2'd3, v); chk("R9 gp in high", v, 8'h12);
    wr_reg(2'd3, 8'h00);
    chk("R9 gp out low", {7'b0, ie_out}, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    wr_reg(2'd3, 8'h04);
    wr_reg(2'd1, 8'h02);
    @(negedge clk);
    iack_n = 0; bus_cs = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h00; #1;
    chk("R11 old vector before edge", bus_rdata, 8'h42);
    @(negedge clk);
    bus_cs = 0; bus_wr = 0; #1;
    chk("R11 request released", {7'b0, irq_n}, 8'h01);
    chk("R11 bus released", {7'b0, bus_oe}, 8'h00);
    iack_n = 1;
    rd_reg(2'd3, v); chk("R11 in-service set", v & 8'h08, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_mask();
    t_vector();
    t_ack_read();
    t_chain();
    t_gp();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule